// File: doc/BRIEF.md
# Write-Masked Clock Gate and Reset Bank

This block holds the gate enables for a set of module clocks and the active-low resets for a set of modules. It sits on a simple memory-mapped read/write bus. Each 32-bit control word splits into a 16-bit data half and a 16-bit write-enable half. Bit n+16 allows a write to bit n. Software can therefore switch one gate or one reset without first reading the word back.

Every control register has a read-only monitor register at a fixed distance of 0x180 bytes. The monitor shows the state that is actually driven, after a two-stage synchroniser clocked by a slow reference tick. Software polls the monitor to confirm that a change has taken effect. A reset is held in the asserted state for a minimum number of reference ticks, even if software asks for its release sooner. The reference clock is an enable pulse, `ref_tick`, in the system clock domain.

Top module: `gate_reset_bank`

## Requirements
- R1: After the synchronous reset `rst`, every `clk_en` bit is 0, every `mod_rst_n` bit is 0 and `bus_rdata` is 0.
- R2: A write to a control register changes data bit n only when bit n+16 of `bus_wdata` is 1. Every other bit keeps its value.
- R3: The gate control words sit at byte address GATE_BASE+4*i (default 0x030). `clk_en[16*i+n]` equals data bit n of word i from the clock edge that accepts the write.
- R4: A read returns its data on `bus_rdata` after the edge that samples `bus_rd`. For a control register, bits 15:0 hold the data and bits 31:16 are 0. `bus_rdata` holds its value between reads.
- R5: The monitor of each control register sits at its address plus 0x180. The monitor reads the driven output state, with bits 31:16 at 0. It follows a change two `ref_tick` pulses later. Writes to a monitor address have no effect.
- R6: The reset control words sit at RST_BASE+4*i (default 0x090). A write with enable 1 and data 0 asserts the reset bit, and `mod_rst_n` goes low on the second edge after the write. A write with enable 1 and data 1 requests the release.
- R7: After an assert write, `mod_rst_n` stays low until MIN_HOLD_TICKS (default 2) `ref_tick` pulses have been sampled. A release requested earlier takes effect on the edge after the count completes.
- R8: A reset monitor bit reads 0 while its reset is driven asserted and 1 once the reset is released.
- R9: A read of any address that does not match a register, including any address with bits 1:0 not zero, returns 0. A write to such an address changes nothing.
- R10: A read and a write to the same register in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per slow reference clock period |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data: upper half enables, lower half data |
| bus_rdata | output | 32 | Registered read data |
| clk_en | output | 16*NUM_GATE_REGS | Module clock gate enables |
| mod_rst_n | output | 16*NUM_RST_REGS | Active-low module resets |

## Verification
A masking fault changes a bit that was not enabled for writing. That bit appears on `clk_en` at the edge of the write, or on `mod_rst_n` one edge later. A wrong hold counter releases a reset within fewer than two reference periods of its assertion, and `mod_rst_n` shows this before the count could have finished. A synchroniser fault makes the monitor read back too early, too late or with wrong bits. A reference model of the whole bank, compared on every clock, catches each of these at the first cycle that diverges.

// File: rtl/gr_pkg.sv
package gr_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_CTRL = 2'd1,
    RK_MON  = 2'd2
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic       is_rst;
    logic [7:0] idx;
  } reg_hit_t;

  // Bits whose enable (upper half) is set take the new data; others hold.
  function automatic logic [HALF_W-1:0] masked_update(
    input logic [HALF_W-1:0] old_val,
    input logic [WORD_W-1:0] wd
  );
    return (old_val & ~wd[WORD_W-1:HALF_W]) | (wd[HALF_W-1:0] & wd[WORD_W-1:HALF_W]);
  endfunction
endpackage

// File: rtl/gr_bus_decode.sv
module gr_bus_decode #(
  parameter int ADDR_W        = 12,
  parameter int NUM_GATE_REGS = 2,
  parameter int NUM_RST_REGS  = 2,
  parameter int GATE_BASE     = 'h030,
  parameter int RST_BASE      = 'h090,
  parameter int MON_OFS       = 'h180
) (
  input  logic [ADDR_W-1:0] addr,
  output gr_pkg::reg_hit_t  hit
);
  import gr_pkg::*;

  always_comb begin
    hit = '{kind: RK_NONE, is_rst: 1'b0, idx: 8'd0};
    for (int i = 0; i < NUM_GATE_REGS; i++) begin
      if (addr == ADDR_W'(GATE_BASE + 4 * i))
        hit = '{kind: RK_CTRL, is_rst: 1'b0, idx: 8'(i)};
      if (addr == ADDR_W'(GATE_BASE + MON_OFS + 4 * i))
        hit = '{kind: RK_MON, is_rst: 1'b0, idx: 8'(i)};
    end
    for (int i = 0; i < NUM_RST_REGS; i++) begin
      if (addr == ADDR_W'(RST_BASE + 4 * i))
        hit = '{kind: RK_CTRL, is_rst: 1'b1, idx: 8'(i)};
      if (addr == ADDR_W'(RST_BASE + MON_OFS + 4 * i))
        hit = '{kind: RK_MON, is_rst: 1'b1, idx: 8'(i)};
    end
  end
endmodule

// File: rtl/gr_wmask_reg.sv
module gr_wmask_reg #(
  parameter int          NUM_REGS  = 2,
  parameter logic [15:0] RESET_VAL = 16'h0000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [7:0]               wr_idx,
  input  logic [31:0]              wdata,
  output logic [NUM_REGS*16-1:0]   ctl_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic sel;
    assign sel = wr_en && (wr_idx == 8'(g));
    // R2: per-bit masked update
    always_ff @(posedge clk) begin
      if (rst)
        ctl_q[g*16 +: 16] <= RESET_VAL;
      else if (sel)
        ctl_q[g*16 +: 16] <= gr_pkg::masked_update(ctl_q[g*16 +: 16], wdata);
    end
  end
endmodule

// File: rtl/gr_ref_sync.sv
module gr_ref_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ref_tick,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  // R5: two stages advanced on the reference tick
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else if (ref_tick) begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gr_reset_hold.sv
module gr_reset_hold #(
  parameter int NUM_REGS       = 2,
  parameter int MIN_HOLD_TICKS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ref_tick,
  input  logic                   wr_en,
  input  logic [7:0]             wr_idx,
  input  logic [31:0]            wdata,
  input  logic [NUM_REGS*16-1:0] rel_req,
  output logic [NUM_REGS*16-1:0] rst_n_q
);
  localparam int HOLD_W = $clog2(MIN_HOLD_TICKS + 1);
  localparam logic [HOLD_W-1:0] CNT_MAX = HOLD_W'(MIN_HOLD_TICKS);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic        sel;
    logic [15:0] restart;
    assign sel     = wr_en && (wr_idx == 8'(g));
    assign restart = sel ? (wdata[31:16] & ~wdata[15:0]) : 16'h0000;

    for (genvar b = 0; b < 16; b++) begin : g_bit
      logic [HOLD_W-1:0] cnt;
      // R7: hold counter restarts on every assert write
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt              <= '0;
          rst_n_q[g*16+b]  <= 1'b0;
        end else begin
          if (restart[b])
            cnt <= '0;
          else if (ref_tick && (cnt != CNT_MAX))
            cnt <= cnt + 1'b1;
          // R6: release only once requested and held long enough
          rst_n_q[g*16+b] <= rel_req[g*16+b] && (cnt == CNT_MAX);
        end
      end
    end
  end
endmodule

// File: rtl/gate_reset_bank.sv
module gate_reset_bank #(
  parameter int ADDR_W         = 12,
  parameter int NUM_GATE_REGS  = 2,
  parameter int NUM_RST_REGS   = 2,
  parameter int GATE_BASE      = 'h030,
  parameter int RST_BASE       = 'h090,
  parameter int MON_OFS        = 'h180,
  parameter int MIN_HOLD_TICKS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ref_tick,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic [NUM_GATE_REGS*16-1:0] clk_en,
  output logic [NUM_RST_REGS*16-1:0]  mod_rst_n
);
  import gr_pkg::*;

  localparam int GW = NUM_GATE_REGS * 16;
  localparam int RW = NUM_RST_REGS * 16;

  reg_hit_t         hit;
  logic             wr_gate;
  logic             wr_rst;
  logic [GW-1:0]    gate_ctl;
  logic [RW-1:0]    rst_ctl;
  logic [GW-1:0]    gate_mon;
  logic [RW-1:0]    rst_mon;
  logic [31:0]      rd_word;

  gr_bus_decode #(
    .ADDR_W       (ADDR_W),
    .NUM_GATE_REGS(NUM_GATE_REGS),
    .NUM_RST_REGS (NUM_RST_REGS),
    .GATE_BASE    (GATE_BASE),
    .RST_BASE     (RST_BASE),
    .MON_OFS      (MON_OFS)
  ) u_dec (
    .addr(bus_addr),
    .hit (hit)
  );

  // R5, R9: monitor and unmapped hits never write
  assign wr_gate = bus_wr && (hit.kind == RK_CTRL) && !hit.is_rst;
  assign wr_rst  = bus_wr && (hit.kind == RK_CTRL) &&  hit.is_rst;

  gr_wmask_reg #(.NUM_REGS(NUM_GATE_REGS), .RESET_VAL(16'h0000)) u_gate_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_gate),
    .wr_idx(hit.idx),
    .wdata (bus_wdata),
    .ctl_q (gate_ctl)
  );

  gr_wmask_reg #(.NUM_REGS(NUM_RST_REGS), .RESET_VAL(16'h0000)) u_rst_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_rst),
    .wr_idx(hit.idx),
    .wdata (bus_wdata),
    .ctl_q (rst_ctl)
  );

  gr_reset_hold #(.NUM_REGS(NUM_RST_REGS), .MIN_HOLD_TICKS(MIN_HOLD_TICKS)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .ref_tick(ref_tick),
    .wr_en   (wr_rst),
    .wr_idx  (hit.idx),
    .wdata   (bus_wdata),
    .rel_req (rst_ctl),
    .rst_n_q (mod_rst_n)
  );

  // R3: gate enables come straight from the control flops
  assign clk_en = gate_ctl;

  gr_ref_sync #(.W(GW)) u_gate_sync (
    .clk     (clk),
    .rst     (rst),
    .ref_tick(ref_tick),
    .d       (clk_en),
    .q       (gate_mon)
  );

  // R8: reset monitor follows the driven reset, not the request
  gr_ref_sync #(.W(RW)) u_rst_sync (
    .clk     (clk),
    .rst     (rst),
    .ref_tick(ref_tick),
    .d       (mod_rst_n),
    .q       (rst_mon)
  );

  // R4: lower half data, upper half zero
  always_comb begin
    rd_word = 32'h0;
    case (hit.kind)
      RK_CTRL: rd_word[15:0] = hit.is_rst ? rst_ctl[16*int'(hit.idx) +: 16]
                                          : gate_ctl[16*int'(hit.idx) +: 16];
      RK_MON:  rd_word[15:0] = hit.is_rst ? rst_mon[16*int'(hit.idx) +: 16]
                                          : gate_mon[16*int'(hit.idx) +: 16];
      default: rd_word = 32'h0;
    endcase
  end

  // R10: read samples state from before any same-cycle write
  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= 32'h0;
    else if (bus_rd)
      bus_rdata <= rd_word;
  end
endmodule

// File: rtl/gr_bank_chk.sv
module gr_bank_chk #(
  parameter int ADDR_W         = 12,
  parameter int NUM_GATE_REGS  = 2,
  parameter int NUM_RST_REGS   = 2,
  parameter int GATE_BASE      = 'h030,
  parameter int RST_BASE       = 'h090,
  parameter int MIN_HOLD_TICKS = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        ref_tick,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [31:0]                 bus_wdata,
  input logic [31:0]                 bus_rdata,
  input logic [NUM_GATE_REGS*16-1:0] clk_en,
  input logic [NUM_RST_REGS*16-1:0]  mod_rst_n
);
  localparam logic [ADDR_W-1:0] G0 = ADDR_W'(GATE_BASE);
  localparam logic [ADDR_W-1:0] R0 = ADDR_W'(RST_BASE);

  logic [7:0] low_ticks;
  always_ff @(posedge clk) begin
    if (rst || mod_rst_n[0])
      low_ticks <= 8'd0;
    else if (ref_tick && low_ticks != 8'hFF)
      low_ticks <= low_ticks + 8'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (clk_en == '0 && mod_rst_n == '0 && bus_rdata == 32'h0));

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == G0) |=>
      (((clk_en[15:0] ^ $past(clk_en[15:0])) & ~$past(bus_wdata[31:16])) == 16'h0));

  // R3
  gate_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == G0) |=>
      (((clk_en[15:0] ^ $past(bus_wdata[15:0])) & $past(bus_wdata[31:16])) == 16'h0));

  // R4
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == G0 || bus_addr == R0)) |=> (bus_rdata[31:16] == 16'h0));

  // R6
  rst_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == R0 && bus_wdata[16] && !bus_wdata[0]) |-> ##2 !mod_rst_n[0]);

  // R7
  rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_rst_n[0]) |-> (int'(low_ticks) >= MIN_HOLD_TICKS - 1));

  // R9
  misaligned_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[1:0] != 2'b00) |=> (bus_rdata == 32'h0));
endmodule

bind gate_reset_bank gr_bank_chk #(
  .ADDR_W        (ADDR_W),
  .NUM_GATE_REGS (NUM_GATE_REGS),
  .NUM_RST_REGS  (NUM_RST_REGS),
  .GATE_BASE     (GATE_BASE),
  .RST_BASE      (RST_BASE),
  .MIN_HOLD_TICKS(MIN_HOLD_TICKS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ref_tick (ref_tick),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .clk_en   (clk_en),
  .mod_rst_n(mod_rst_n)
);

// File: tb/gate_reset_bank_bench.sv
module gate_reset_bank_bench;
  localparam int NG      = 2;
  localparam int NR      = 2;
  localparam int AW      = 12;
  localparam int GB      = 'h030;
  localparam int RB      = 'h090;
  localparam int MO      = 'h180;
  localparam int MH      = 2;
  localparam int REF_DIV = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_tick = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NG*16-1:0] clk_en;
  logic [NR*16-1:0] mod_rst_n;

  int checks = 0;
  int errors = 0;
  logic live = 1'b0;

  always #5 clk = ~clk;

  gate_reset_bank u_gate_reset_bank (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_en(clk_en), .mod_rst_n(mod_rst_n)
  );

  // reference tick: one pulse every REF_DIV clocks
  initial begin
    forever begin
      repeat (REF_DIV - 1) @(negedge clk);
      ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
    end
  end

  // ---------------- behavioural reference model ----------------
  logic [NG*16-1:0] m_g, m_gs1, m_gs2;
  logic [NR*16-1:0] m_r, m_rout, m_rs1, m_rs2, m_nxt;
  int               m_cnt [NR*16];
  logic [31:0]      m_rd;

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    logic [31:0] v = 32'h0;
    for (int i = 0; i < NG; i++) begin
      if (int'(a) == GB + 4*i)      v = {16'h0, m_g[i*16 +: 16]};
      if (int'(a) == GB + MO + 4*i) v = {16'h0, m_gs2[i*16 +: 16]};
    end
    for (int i = 0; i < NR; i++) begin
      if (int'(a) == RB + 4*i)      v = {16'h0, m_r[i*16 +: 16]};
      if (int'(a) == RB + MO + 4*i) v = {16'h0, m_rs2[i*16 +: 16]};
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_g = '0; m_gs1 = '0; m_gs2 = '0;
      m_r = '0; m_rout = '0; m_rs1 = '0; m_rs2 = '0;
      m_rd = '0;
      for (int b = 0; b < NR*16; b++) m_cnt[b] = 0;
    end else begin
      if (bus_rd) m_rd = model_read(bus_addr);
      if (ref_tick) begin
        m_gs2 = m_gs1; m_gs1 = m_g;
        m_rs2 = m_rs1; m_rs1 = m_rout;
      end
      for (int b = 0; b < NR*16; b++) begin
        m_nxt[b] = m_r[b] && (m_cnt[b] == MH);
        if (bus_wr && int'(bus_addr) == RB + 4*(b/16) &&
            bus_wdata[16 + b%16] && !bus_wdata[b%16])
          m_cnt[b] = 0;
        else if (ref_tick && m_cnt[b] < MH)
          m_cnt[b] = m_cnt[b] + 1;
      end
      m_rout = m_nxt;
      if (bus_wr) begin
        for (int i = 0; i < NG; i++)
          if (int'(bus_addr) == GB + 4*i)
            m_g[i*16 +: 16] = (m_g[i*16 +: 16] & ~bus_wdata[31:16]) |
                              (bus_wdata[15:0] & bus_wdata[31:16]);
        for (int i = 0; i < NR; i++)
          if (int'(bus_addr) == RB + 4*i)
            m_r[i*16 +: 16] = (m_r[i*16 +: 16] & ~bus_wdata[31:16]) |
                              (bus_wdata[15:0] & bus_wdata[31:16]);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (live && !rst) begin
      chk("R3 clk_en lo", clk_en[31:0] & 32'hFFFFFFFF, m_g[31:0]);
      chk("R7 mod_rst_n", mod_rst_n[31:0], m_rout[31:0]);
      chk("R4 bus_rdata", bus_rdata, m_rd);
    end
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_rw(input int a, input logic [31:0] wd, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = wd; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 clk_en", clk_en, 32'h0);
    chk("R1 mod_rst_n", mod_rst_n, 32'h0);
    chk("R1 bus_rdata", bus_rdata, 32'h0);

    // R2, R3, R4 basic masked write and readback
    bus_write(GB, 32'h00FF_00A5);
    chk("R3 gate0 out", {16'h0, clk_en[15:0]}, 32'h0000_00A5);
    bus_read(GB, rd);
    chk("R4 gate0 read", rd, 32'h0000_00A5);
    bus_write(GB, 32'h0003_FFFC);
    bus_read(GB, rd);
    chk("R2 partial mask", rd, 32'h0000_00A4);

    // R5 monitor delay and readback
    bus_write(GB + 4, 32'hFFFF_1234);
    bus_read(GB + MO + 4, rd);
    chk("R5 monitor not yet", rd, 32'h0);
    repeat (3*REF_DIV) @(negedge clk);
    bus_read(GB + MO + 4, rd);
    chk("R5 monitor settled", rd, 32'h0000_1234);
    bus_read(GB + MO, rd);
    chk("R5 monitor gate0", rd, 32'h0000_00A4);
    bus_write(GB + MO, 32'hFFFF_FFFF);
    bus_read(GB, rd);
    chk("R5 monitor write ignored", rd, 32'h0000_00A4);

    // R9 unmapped and misaligned
    bus_write('h000, 32'hFFFF_FFFF);
    bus_write(GB + 1, 32'hFFFF_0000);
    bus_read('h000, rd);
    chk("R9 unmapped read", rd, 32'h0);
    bus_read(GB + 1, rd);
    chk("R9 misaligned read", rd, 32'h0);
    bus_read(GB, rd);
    chk("R9 no side effect", rd, 32'h0000_00A4);

    // R6 release all of reset word 0 (hold long satisfied)
    bus_write(RB, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R6 release", {16'h0, mod_rst_n[15:0]}, 32'h0000_FFFF);
    chk("R6 word1 still held", {16'h0, mod_rst_n[31:16]}, 32'h0);
    repeat (3*REF_DIV) @(negedge clk);
    bus_read(RB + MO, rd);
    chk("R8 monitor released", rd, 32'h0000_FFFF);

    // R6, R7 short pulse: release requested immediately
    bus_write(RB, 32'h0008_0000);
    @(negedge clk);
    chk("R6 assert bit3", {16'h0, mod_rst_n[15:0]}, 32'h0000_FFF7);
    bus_write(RB, 32'h0008_0008);
    @(negedge clk);
    chk("R7 held after early release", {16'h0, mod_rst_n[15:0]}, 32'h0000_FFF7);
    repeat (3*REF_DIV) @(negedge clk);
    chk("R7 released after hold", {16'h0, mod_rst_n[15:0]}, 32'h0000_FFFF);

    // R8 monitor while asserted
    bus_write(RB, 32'h0020_0000);
    repeat (3*REF_DIV + 4) @(negedge clk);
    bus_read(RB + MO, rd);
    chk("R8 monitor asserted", rd, 32'h0000_FFDF);
    bus_write(RB, 32'h0020_0020);

    // R10 same-cycle read and write
    bus_rw(GB + 4, 32'hFFFF_0000, rd);
    chk("R10 old value", rd, 32'h0000_1234);
    bus_read(GB + 4, rd);
    chk("R10 new value", rd, 32'h0);

    // random traffic, checked by the model every clock
    for (int n = 0; n < 400; n++) begin
      int pick;
      int a;
      pick = int'($urandom_range(0, 8));
      case (pick)
        0: a = GB;      1: a = GB + 4;   2: a = RB;       3: a = RB + 4;
        4: a = GB + MO; 5: a = RB + MO;  6: a = RB + MO + 4;
        7: a = 'h000;   default: a = GB + 2;
      endcase
      @(negedge clk);
      bus_addr  = AW'(a);
      bus_wdata = $urandom;
      bus_wr    = $urandom_range(0, 1) == 1;
      bus_rd    = $urandom_range(0, 1) == 1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      repeat (int'($urandom_range(0, 6))) @(negedge clk);
    end

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule